// File: doc/BRIEF.md
# Multi-Channel PWM Generator with End-of-Cycle Register Update

This block produces a set of independent pulse-width modulated outputs. Each channel runs its own counter against an active period value and an active duty value. Software changes a running channel through one update register per channel. A mode bit steers that register to either the period or the duty. The new value reaches the active register only when the current PWM cycle ends, so no output cycle is ever cut short or stretched.

Every end of cycle raises the channel's bit in a shared status word. Software polls that word, or enables the channel's interrupt, to learn that its last update has been applied. Reading the status word clears every flag at once. Polarity and alignment (left or center) are locked while a channel runs. A simple single-cycle write/read register port gives access to all settings. Reads are combinational, and a write takes effect at the next clock edge.

Top module: `pwm_sync_ctrl`

## Requirements
- R1: Left-aligned mode (mode bit 1 = 0): an enabled channel counts 0 up to P-1 and wraps, giving a period of P cycles. Its output is high while the count is below D. P is at address 9+4*i and D at address 10+4*i for channel i. Bit i of the enable word at address 0 runs channel i.
- R2: A value written to the update register (address 11+4*i) leaves the active period and duty unchanged until the channel's current cycle ends. The value is applied from the first count of the next cycle.
- R3: Mode bit 2 (mode register at address 8+4*i) picks the destination of the update. A 1 sends it to the period and a 0 sends it to the duty.
- R4: When the update register is written more than once within one cycle, only the last value is applied at the end of the cycle.
- R5: Every end of cycle of an enabled channel i sets bit i of the status word at address 2.
- R6: A read of address 2 returns the flags and clears all of them at the same clock edge. A flag raised in that same cycle survives.
- R7: The `irq` output is high exactly when some status flag is set and the matching bit of the interrupt-enable word at address 1 is also set.
- R8: While a channel is enabled, writes to its polarity (mode bit 0), its alignment (mode bit 1), and its direct period and duty registers are ignored. Mode bit 2 stays writable.
- R9: A disabled channel drives its inactive level, which equals its polarity bit. Its counter restarts at 0 when it is enabled. With polarity 1 the enabled output is inverted.
- R10: Center-aligned mode (mode bit 1 = 1): the count goes 0,1..P then P-1..1, and the cycle ends on the return to 0. One cycle lasts 2*P clocks, and the output is high while the count is below D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 2) |
| addr | input | 6 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| pwm_out | output | 4 | One PWM output per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus never asserts a read and a write in the same cycle, and that every strobe lasts one clock. They also assume that alignment and polarity change only through the register port, so the counter-bound check can rely on the period moving only at cycle ends or while the channel is stopped. The bench drives every access from one task per kind, setting the strobe just after a falling edge and dropping it one clock later. Each scenario first stops and reconfigures its channel, so the counter phase is known whenever an output is sampled.

// File: rtl/pwm_sync_pkg.sv
// Package: shared parameters and register map for the PWM controller.
// Assumes a word-addressed register port; channel i occupies four words
// starting at CH_BASE + 4*i.
package pwm_sync_pkg;
    localparam int unsigned ADDR_W   = 6;
    localparam int unsigned ADR_ENA  = 0;
    localparam int unsigned ADR_IEN  = 1;
    localparam int unsigned ADR_STAT = 2;
    localparam int unsigned CH_BASE  = 8;
    // field offsets inside a channel window
    localparam logic [1:0] FLD_MODE = 2'd0;
    localparam logic [1:0] FLD_PER  = 2'd1;
    localparam logic [1:0] FLD_DTY  = 2'd2;
    localparam logic [1:0] FLD_UPD  = 2'd3;
    // mode register bit positions
    localparam int unsigned MB_POL = 0;
    localparam int unsigned MB_CTR = 1;
    localparam int unsigned MB_TGT = 2;
endpackage

// File: rtl/pwm_sync_chan.sv
// Module: one PWM channel. Holds the active period and duty, the update
// buffer and its pending bit, the counter and the output stage.
// Assumes wr_* strobes are single-cycle and mutually exclusive.
module pwm_sync_chan
    import pwm_sync_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wr_mode,
    input  logic         wr_per,
    input  logic         wr_dty,
    input  logic         wr_upd,
    input  logic [W-1:0] wdata,
    output logic [2:0]   mode_q,
    output logic [W-1:0] per_q,
    output logic [W-1:0] dty_q,
    output logic [W-1:0] upd_q,
    output logic         eoc,
    output logic         pwm
);
    logic         pol, ctr, tgt, pend, up;
    logic [W-1:0] cnt;
    logic         left_end;

    // end-of-cycle detect for both alignments
    always_comb begin
        left_end = ({1'b0, cnt} + {{W{1'b0}}, 1'b1}) >= {1'b0, per_q};
        eoc      = en && (ctr ? (!up && cnt == '0) : left_end);
        pwm      = en ? ((cnt < dty_q) ^ pol) : pol;
        mode_q   = {tgt, ctr, pol};
    end

    // settings: mode, direct writes (only while stopped), update transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol   <= 1'b0;
            ctr   <= 1'b0;
            tgt   <= 1'b0;
            per_q <= '0;
            dty_q <= '0;
            upd_q <= '0;
            pend  <= 1'b0;
        end else begin
            if (wr_mode) begin
                tgt <= wdata[MB_TGT];
                if (!en) begin
                    pol <= wdata[MB_POL];
                    ctr <= wdata[MB_CTR];
                end
            end
            if (wr_per && !en) per_q <= wdata;
            if (wr_dty && !en) dty_q <= wdata;
            if (eoc && pend) begin
                if (tgt) per_q <= upd_q;
                else     dty_q <= upd_q;
            end
            if (wr_upd) begin
                upd_q <= wdata;
                pend  <= 1'b1;
            end else if (eoc) begin
                pend  <= 1'b0;
            end
        end
    end

    // counter: left wraps at P-1, center bounces between 0 and P
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (!ctr) begin
            cnt <= left_end ? '0 : cnt + 1'b1;
        end else if (up) begin
            if (cnt >= per_q) begin
                up  <= 1'b0;
                cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= (per_q == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R2
    per_at_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && per_q != $past(per_q)) |-> $past(eoc));
    // R2
    dty_at_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && dty_q != $past(dty_q)) |-> $past(eoc));
    // R8
    pol_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_mode) |=> (pol == $past(pol) && ctr == $past(ctr)));
    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ctr && per_q != '0) |-> (cnt < per_q));
endmodule

// File: rtl/pwm_sync_flags.sv
// Module: shared status flags with clear-on-read and masked interrupt.
// Assumes set pulses come one cycle wide from each channel's end of cycle.
module pwm_sync_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    input  logic [N-1:0] ien,
    output logic [N-1:0] flags,
    output logic         irq
);
    // flag register: read clears, a same-cycle set wins
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr ? '0 : flags) | set;
    end

    // combined interrupt
    always_comb irq = |(flags & ien);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flags & $past(set)) == $past(set)));
    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (flags == '0));
    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);
endmodule

// File: rtl/pwm_sync_ctrl.sv
// Module: top level. Decodes the register port, holds the enable and
// interrupt-enable words, instantiates the channels and the flag block.
// Assumes DW > NCH and never a read and a write in the same cycle.
module pwm_sync_ctrl
    import pwm_sync_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic              irq
);
    localparam int unsigned WIN_W    = ADDR_W - 2;
    localparam int unsigned WIN_BASE = CH_BASE / 4;

    logic [NCH-1:0] ena, ien, flags, eoc_v;
    logic [2:0]     mode_a [NCH];
    logic [DW-1:0]  per_a  [NCH];
    logic [DW-1:0]  dty_a  [NCH];
    logic [DW-1:0]  upd_a  [NCH];
    logic           stat_rd;

    always_comb stat_rd = rd_en && addr == ADDR_W'(ADR_STAT);

    // global enable and interrupt-enable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena <= '0;
            ien <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_ENA)) ena <= wdata[NCH-1:0];
            if (addr == ADDR_W'(ADR_IEN)) ien <= wdata[NCH-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        always_comb hit = wr_en && addr[ADDR_W-1:2] == WIN_W'(WIN_BASE + i);
        pwm_sync_chan #(.W(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ena[i]),
            .wr_mode (hit && addr[1:0] == FLD_MODE),
            .wr_per  (hit && addr[1:0] == FLD_PER),
            .wr_dty  (hit && addr[1:0] == FLD_DTY),
            .wr_upd  (hit && addr[1:0] == FLD_UPD),
            .wdata   (wdata),
            .mode_q  (mode_a[i]),
            .per_q   (per_a[i]),
            .dty_q   (dty_a[i]),
            .upd_q   (upd_a[i]),
            .eoc     (eoc_v[i]),
            .pwm     (pwm_out[i])
        );
    end

    pwm_sync_flags #(.N(NCH)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (eoc_v),
        .clr   (stat_rd),
        .ien   (ien),
        .flags (flags),
        .irq   (irq)
    );

    // read mux over global words and channel windows
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_ENA))  rdata = {{(DW-NCH){1'b0}}, ena};
        if (addr == ADDR_W'(ADR_IEN))  rdata = {{(DW-NCH){1'b0}}, ien};
        if (addr == ADDR_W'(ADR_STAT)) rdata = {{(DW-NCH){1'b0}}, flags};
        for (int i = 0; i < NCH; i++) begin
            if (addr[ADDR_W-1:2] == WIN_W'(WIN_BASE + i)) begin
                case (addr[1:0])
                    FLD_MODE: rdata = {{(DW-3){1'b0}}, mode_a[i]};
                    FLD_PER:  rdata = per_a[i];
                    FLD_DTY:  rdata = dty_a[i];
                    default:  rdata = upd_a[i];
                endcase
            end
        end
    end
endmodule

// File: tb/pwm_sync_ctrl_test.sv
module pwm_sync_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  pwm_out;
    logic        irq;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    pwm_sync_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] ca(int ch, int fld);
        return 6'(8 + 4*ch + fld);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all tasks start just after a falling edge and end just after one
    task automatic wr(logic [5:0] a, logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output int v);
        rd_en = 1'b1; addr = a;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_left(string tag, int ch, int start, int per, int dty, int pol, int n);
        for (int i = 0; i < n; i++) begin
            int c = (start + i) % per;
            chk(tag, int'(pwm_out[ch]), int'((c < dty) ? 1 - pol : pol));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int v;
        chk("R9 reset outputs", int'(pwm_out), 0);
        chk("R7 reset irq", int'(irq), 0);
        rd(6'd2, v);
        chk("R5 reset status", v, 0);
    endtask

    task automatic t_left();
        wr(ca(0,1), 16'd4);
        wr(ca(0,2), 16'd2);
        chk("R9 stopped output", int'(pwm_out[0]), 0);
        wr(6'd0, 16'h1);
        run_left("R1 left wave", 0, 0, 4, 2, 0, 8);
    endtask

    task automatic t_upd_duty();
        wr(6'd0, 16'h0);
        wr(6'd0, 16'h1);
        run_left("R2 before update", 0, 0, 4, 2, 0, 1);
        wr(ca(0,3), 16'd3);
        // now at count 2: old duty 2 gives low, new duty 3 would give high
        run_left("R2 old duty held", 0, 2, 4, 2, 0, 2);
        run_left("R2 new duty applied", 0, 0, 4, 3, 0, 8);
    endtask

    task automatic t_lock();
        int v;
        wr(ca(0,0), 16'h1);
        chk("R8 polarity write ignored (out)", int'(pwm_out[0]), 1);
        rd(ca(0,0), v);
        chk("R8 polarity write ignored (mode)", v, 0);
        wr(ca(0,1), 16'd9);
        rd(ca(0,1), v);
        chk("R8 period write ignored", v, 4);
        wr(6'd0, 16'h0);
        chk("R9 disabled inactive low", int'(pwm_out[0]), 0);
        wr(ca(0,0), 16'h1);
        chk("R9 disabled inactive high", int'(pwm_out[0]), 1);
        wr(6'd0, 16'h1);
        run_left("R9 inverted wave", 0, 0, 4, 3, 1, 8);
        wr(6'd0, 16'h0);
    endtask

    task automatic t_status();
        int v;
        wr(6'd0, 16'h0);
        rd(6'd2, v);
        wr(ca(1,1), 16'd20);
        wr(ca(1,2), 16'd5);
        wr(6'd0, 16'h2);
        rd(6'd2, v);
        chk("R5 no flag mid cycle", v, 0);
        repeat (19) @(negedge clk);
        chk("R7 masked irq", int'(irq), 0);
        rd(6'd2, v);
        chk("R5 flag at end of cycle", v, 2);
        rd(6'd2, v);
        chk("R6 cleared by read", v, 0);
        repeat (18) @(negedge clk);
        chk("R7 irq off while disabled mask", int'(irq), 0);
        wr(6'd1, 16'h2);
        chk("R7 irq on", int'(irq), 1);
        rd(6'd2, v);
        chk("R7 irq drops after read", int'(irq), 0);
        wr(6'd0, 16'h0);
    endtask

    task automatic t_upd_period();
        wr(ca(2,1), 16'd4);
        wr(ca(2,2), 16'd2);
        wr(ca(2,0), 16'h4);
        wr(6'd0, 16'h4);
        wr(ca(2,3), 16'd6);
        run_left("R3 old period held", 2, 1, 4, 2, 0, 3);
        run_left("R3 period target", 2, 0, 6, 2, 0, 12);
        wr(6'd0, 16'h0);
    endtask

    task automatic t_double();
        wr(ca(3,1), 16'd8);
        wr(ca(3,2), 16'd1);
        wr(6'd0, 16'h8);
        wr(ca(3,3), 16'd7);
        wr(ca(3,3), 16'd3);
        run_left("R4 old duty held", 3, 2, 8, 1, 0, 6);
        run_left("R4 latest value", 3, 0, 8, 3, 0, 8);
        wr(6'd0, 16'h0);
    endtask

    task automatic t_center();
        wr(ca(1,1), 16'd3);
        wr(ca(1,2), 16'd2);
        wr(ca(1,0), 16'h2);
        wr(6'd0, 16'h2);
        for (int i = 0; i < 14; i++) begin
            int m = i % 6;
            int c = (m <= 3) ? m : 6 - m;
            chk("R10 center wave", int'(pwm_out[1]), (c < 2) ? 1 : 0);
            @(negedge clk);
        end
        wr(6'd0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_left();
        t_upd_duty();
        t_lock();
        t_status();
        t_upd_period();
        t_double();
        t_center();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule